// File: doc/BRIEF.md
# Sequential Switch-Scan Change-Interrupt Controller

This block sequences a multi-input switch monitor around one shared comparator. Software sets a run bit. The controller then waits a programmable number of clock cycles for the wetting current to settle. After that it selects each enabled input in ascending index order and holds each one on the comparator for a programmable compare time. It latches the comparator decision for that input into a per-input status bit. Inputs whose enable bit is low are passed over without spending any cycles on them.

Passes repeat at a programmable period, measured from the start of one pass to the start of the next. A period shorter than a pass is stretched to the length of the pass. The first pass after the run bit is set only establishes the reference states, and it always raises the change flag and pulls the active-low interrupt low. Later passes raise them only when at least one input decides differently from its stored bit. A status-read strobe clears the flag. A new event in the same cycle as the read wins, so no event is lost.

Top module: `swscan_ctrl`

## Requirements
- R1: Out of reset, `int_n` is 1, `chg_flag` is 0, `ch_valid` is 0 and every `sw_status` bit is 0.
- R2: Writing a 1 to bit 0 at address 0 (the run bit) starts the block. The first channel selection is visible after the (S+2)th rising edge that follows the edge capturing that write, where S is the value written at address 1.
- R3: Within a pass, `ch_sel` takes the indices of the inputs whose `en_mask` bit is 1, in ascending order. An input whose mask bit is 0 is never selected.
- R4: Each selected input stays on `ch_sel` with `ch_valid` high for C consecutive cycles, where C is the value at address 2 and a value of 0 acts as 1. `cmp_in` in the last of those cycles is stored into that input's `sw_status` bit. No other cycle changes `sw_status`.
- R5: At the end of the first pass after the run bit is set, `chg_flag` becomes 1 and `int_n` becomes 0, even if no input changed.
- R6: A later pass sets `chg_flag` only if some enabled input's sampled value differs from its stored bit. Toggling the input of a disabled channel has no effect.
- R7: A one-cycle `stat_rd` pulse clears `chg_flag` and returns `int_n` to 1.
- R8: If a pass ends with an event in the same cycle as `stat_rd`, `chg_flag` is 1 afterwards.
- R9: The interval between the starts of consecutive passes is max(P, L) cycles. P is the value at address 3. L is the number of enabled inputs times C, or 1 when no input is enabled.
- R10: Clearing the run bit lets the input under compare finish its full hold, then stops all selection without reporting a pass end. Setting the run bit again starts a new first pass.
- R11: With no input enabled, the first pass still raises the flag. After that no channel is selected and no change flag occurs, whatever `cmp_in` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 run bit, 1 startup cycles, 2 compare cycles, 3 poll period |
| cfg_wdata | input | CNT_W (16) | Write data |
| en_mask | input | N_IN (24) | Per-input enable |
| cmp_in | input | 1 | Comparator decision for the selected input (1 = above threshold) |
| stat_rd | input | 1 | Interrupt-status read strobe, clears the flag |
| ch_sel | output | SEL_W (5) | Selected input index, 0 when nothing is selected |
| ch_valid | output | 1 | An input is routed to the comparator |
| sw_status | output | N_IN (24) | Stored decision per input |
| chg_flag | output | 1 | Status-change flag |
| int_n | output | 1 | Active-low interrupt |

## Verification
The scan order and hold time are tried with a sparse mask that has gaps, a full mask and an empty mask. These separate a correct skip of disabled inputs from an off-by-one in the next-index search, and an empty pass from a stuck sequencer. The change detector is swept by flipping every one of the 24 inputs in turn, and by flipping a disabled input. Each case shows whether a difference at that index, and only at an enabled index, reaches the flag. The poll period is set both above and below the pass length, which shows the pass-stretching rule. The read strobe is timed to the final compare cycle of a pass, and the run bit is dropped at the start of a compare, to exercise the race and stop corners.

// File: rtl/swscan_pkg.sv
package swscan_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_SCAN  = 2'd2,
    ST_WAIT  = 2'd3
  } scan_st_t;

  localparam logic [1:0] ADR_RUN   = 2'd0;
  localparam logic [1:0] ADR_SETTL = 2'd1;
  localparam logic [1:0] ADR_HOLD  = 2'd2;
  localparam logic [1:0] ADR_POLL  = 2'd3;

endpackage

// File: rtl/swscan_cfg.sv
module swscan_cfg
  import swscan_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic             run,
  output logic [CNT_W-1:0] settle_cyc,
  output logic [CNT_W-1:0] hold_cyc,
  output logic [CNT_W-1:0] poll_cyc
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      settle_cyc <= '0;
      hold_cyc   <= CNT_W'(1);
      poll_cyc   <= '0;
    end else if (cfg_wr) begin
      case (cfg_addr)
        ADR_RUN:   run        <= cfg_wdata[0];
        ADR_SETTL: settle_cyc <= cfg_wdata;
        ADR_HOLD:  hold_cyc   <= cfg_wdata;
        default:   poll_cyc   <= cfg_wdata;
      endcase
    end
  end

endmodule

// File: rtl/swscan_seq.sv
module swscan_seq
  import swscan_pkg::*;
#(
  parameter int N_IN  = 24,
  parameter int CNT_W = 16,
  parameter int SEL_W = 5,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [CNT_W-1:0] settle_cyc,
  input  logic [CNT_W-1:0] hold_cyc,
  input  logic [CNT_W-1:0] poll_cyc,
  input  logic [N_IN-1:0]  en_mask,
  input  logic             diff_now,
  output logic             ch_valid,
  output logic [SEL_W-1:0] ch_sel,
  output logic             samp_ev,
  output logic             set_ev
);

  localparam logic [IDX_W-1:0] NONE = IDX_W'(N_IN);

  // lowest enabled index at or above 'from', NONE if there is none
  function automatic logic [IDX_W-1:0] next_enabled(input logic [N_IN-1:0] m,
                                                    input logic [IDX_W-1:0] from);
    logic [IDX_W-1:0] r;
    r = NONE;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (m[i] && (i >= int'(from))) r = IDX_W'(i);
    end
    return r;
  endfunction

  // index of the sampling cycle within a hold; zero acts as one cycle
  function automatic logic [CNT_W-1:0] hold_last(input logic [CNT_W-1:0] c);
    return (c == '0) ? '0 : c - 1'b1;
  endfunction

  // next pass may start once start-to-start distance reaches the period
  function automatic logic period_done(input logic [CNT_W-1:0] p,
                                       input logic [CNT_W-1:0] per);
    return ({1'b0, p} + (CNT_W+1)'(1)) >= {1'b0, per};
  endfunction

  scan_st_t         st_q;
  logic [CNT_W-1:0] tmr_q, pcnt_q, pcnt_inc;
  logic [IDX_W-1:0] idx_q, nxt_idx, first_idx;
  logic             first_q, pchg_q;
  logic             empty_ev, boundary, last_ev, chg_now, pass_end;

  assign ch_valid  = (st_q == ST_SCAN) && (idx_q != NONE);
  assign ch_sel    = ch_valid ? idx_q[SEL_W-1:0] : '0;
  assign samp_ev   = ch_valid && (tmr_q >= hold_last(hold_cyc));
  assign empty_ev  = (st_q == ST_SCAN) && (idx_q == NONE);
  assign boundary  = samp_ev || empty_ev;
  assign nxt_idx   = next_enabled(en_mask, idx_q + 1'b1);
  assign first_idx = next_enabled(en_mask, '0);
  assign last_ev   = empty_ev || (samp_ev && (nxt_idx == NONE));
  assign chg_now   = samp_ev && !first_q && diff_now;
  assign pass_end  = last_ev && run;
  assign set_ev    = pass_end && (first_q || pchg_q || chg_now);
  assign pcnt_inc  = (&pcnt_q) ? pcnt_q : pcnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      tmr_q   <= '0;
      pcnt_q  <= '0;
      idx_q   <= NONE;
      first_q <= 1'b1;
      pchg_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          first_q <= 1'b1;
          if (run) begin
            st_q  <= ST_START;
            tmr_q <= '0;
          end
        end
        ST_START: begin
          if (!run) st_q <= ST_IDLE;
          else if (tmr_q >= settle_cyc) begin
            st_q   <= ST_SCAN;
            idx_q  <= first_idx;
            tmr_q  <= '0;
            pcnt_q <= '0;
            pchg_q <= 1'b0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        ST_SCAN: begin
          if (!boundary) begin
            tmr_q  <= tmr_q + 1'b1;
            pcnt_q <= pcnt_inc;
          end else if (!run) begin
            st_q <= ST_IDLE;
          end else if (last_ev) begin
            first_q <= 1'b0;
            if (period_done(pcnt_q, poll_cyc)) begin
              idx_q  <= first_idx;
              tmr_q  <= '0;
              pcnt_q <= '0;
              pchg_q <= 1'b0;
            end else begin
              st_q   <= ST_WAIT;
              pcnt_q <= pcnt_inc;
            end
          end else begin
            idx_q  <= nxt_idx;
            tmr_q  <= '0;
            pcnt_q <= pcnt_inc;
            pchg_q <= pchg_q | chg_now;
          end
        end
        default: begin
          if (!run) st_q <= ST_IDLE;
          else if (period_done(pcnt_q, poll_cyc)) begin
            st_q   <= ST_SCAN;
            idx_q  <= first_idx;
            tmr_q  <= '0;
            pcnt_q <= '0;
            pchg_q <= 1'b0;
          end else pcnt_q <= pcnt_inc;
        end
      endcase
    end
  end

  AST_HOLD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_valid && !samp_ev) |=> (ch_valid && $stable(ch_sel))); // R4

  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ch_valid) |=> !ch_valid); // R10

endmodule

// File: rtl/swscan_stat.sv
module swscan_stat #(
  parameter int N_IN  = 24,
  parameter int SEL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             samp_ev,
  input  logic [SEL_W-1:0] ch_sel,
  input  logic             cmp_in,
  output logic [N_IN-1:0]  status,
  output logic             diff_now
);

  assign diff_now = status[ch_sel] != cmp_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else if (samp_ev) status[ch_sel] <= cmp_in;
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_ev |=> $stable(status)); // R4

endmodule

// File: rtl/swscan_irq.sv
module swscan_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic stat_rd,
  output logic flag,
  output logic int_n
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_ev | (flag & ~stat_rd);
  end

  assign int_n = ~flag;

  AST_RD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_ev) |=> (!flag && int_n)); // R7

  AST_RD_RACE: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag); // R8

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag && !set_ev) |=> !flag); // R6

endmodule

// File: rtl/swscan_ctrl.sv
module swscan_ctrl
  import swscan_pkg::*;
#(
  parameter int N_IN  = 24,
  parameter int CNT_W = 16,
  localparam int SEL_W = $clog2(N_IN),
  localparam int IDX_W = $clog2(N_IN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [1:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  input  logic [N_IN-1:0]  en_mask,
  input  logic             cmp_in,
  input  logic             stat_rd,
  output logic [SEL_W-1:0] ch_sel,
  output logic             ch_valid,
  output logic [N_IN-1:0]  sw_status,
  output logic             chg_flag,
  output logic             int_n
);

  logic             run;
  logic [CNT_W-1:0] settle_cyc, hold_cyc, poll_cyc;
  logic             samp_ev, set_ev, diff_now;

  swscan_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .run(run), .settle_cyc(settle_cyc),
    .hold_cyc(hold_cyc), .poll_cyc(poll_cyc)
  );

  swscan_seq #(.N_IN(N_IN), .CNT_W(CNT_W), .SEL_W(SEL_W), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .settle_cyc(settle_cyc),
    .hold_cyc(hold_cyc), .poll_cyc(poll_cyc), .en_mask(en_mask),
    .diff_now(diff_now), .ch_valid(ch_valid), .ch_sel(ch_sel),
    .samp_ev(samp_ev), .set_ev(set_ev)
  );

  swscan_stat #(.N_IN(N_IN), .SEL_W(SEL_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .samp_ev(samp_ev), .ch_sel(ch_sel),
    .cmp_in(cmp_in), .status(sw_status), .diff_now(diff_now)
  );

  swscan_irq u_irq (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .stat_rd(stat_rd),
    .flag(chg_flag), .int_n(int_n)
  );

endmodule

// File: tb/tb_swscan_ctrl.sv
module tb_swscan_ctrl;

  localparam int N = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [N-1:0] en_mask = '0;
  logic [N-1:0] sw = '0;
  logic        stat_rd = 1'b0;
  logic        cmp_in;
  logic [4:0]  ch_sel;
  logic        ch_valid, chg_flag, int_n;
  logic [N-1:0] sw_status;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  assign cmp_in = sw[ch_sel];

  swscan_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .en_mask(en_mask), .cmp_in(cmp_in),
    .stat_rd(stat_rd), .ch_sel(ch_sel), .ch_valid(ch_valid),
    .sw_status(sw_status), .chg_flag(chg_flag), .int_n(int_n)
  );

  // run-length monitor of the selection output
  int log_sel [0:4095];
  int log_len [0:4095];
  int log_st  [0:4095];
  int nlog = 0, ncyc = 0, cur_run = 0, cur_st = 0;
  bit pv = 1'b0;
  int ps = 0;

  always @(negedge clk) begin
    ncyc++;
    if (ch_valid) begin
      if (pv && int'(ch_sel) == ps) cur_run++;
      else begin
        if (pv) begin
          log_sel[nlog % 4096] = ps; log_len[nlog % 4096] = cur_run;
          log_st[nlog % 4096] = cur_st; nlog++;
        end
        cur_run = 1; cur_st = ncyc;
      end
    end else begin
      if (pv) begin
        log_sel[nlog % 4096] = ps; log_len[nlog % 4096] = cur_run;
        log_st[nlog % 4096] = cur_st; nlog++;
      end
      cur_run = 0;
    end
    pv = ch_valid;
    ps = int'(ch_sel);
  end

  task automatic tick(input int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic read_stat();
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
  endtask

  task automatic wait_gap();
    int g = 0;
    while (ch_valid && g < 500) begin tick(); g++; end
  endtask

  function automatic int start_gap(input int sel);
    int found = 0, a = 0, b = 0;
    for (int i = nlog - 1; i >= 0 && i >= nlog - 4000 && found < 2; i--) begin
      if (log_sel[i % 4096] == sel) begin
        if (found == 0) a = log_st[i % 4096]; else b = log_st[i % 4096];
        found++;
      end
    end
    return a - b;
  endfunction

  function automatic int pop(input logic [N-1:0] m);
    int c = 0;
    for (int i = 0; i < N; i++) c += int'(m[i]);
    return c;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int base, k, e, lp;
    logic [N-1:0] m1;
    tick(3);
    // R1 reset state
    chk("R1 int_n", 32'(int_n), 1);
    chk("R1 flag", 32'(chg_flag), 0);
    chk("R1 valid", 32'(ch_valid), 0);
    chk("R1 status", 32'(sw_status), 0);
    rst_n = 1'b1;
    tick(2);

    m1 = 24'h800A11;
    en_mask = m1;
    sw = 24'h00081B;
    cfg_write(2'd1, 16'd3);
    cfg_write(2'd2, 16'd2);
    cfg_write(2'd3, 16'd60);
    tick(5);
    chk("R2 idle before run", 32'(ch_valid), 0);
    base = nlog;
    cfg_write(2'd0, 16'd1);
    k = 0;
    while (k < 50) begin tick(); k++; if (ch_valid) break; end
    chk("R2 startup delay", 32'(k), 32'(3 + 2));
    tick(40);
    // R5 first pass baseline interrupt
    chk("R5 flag", 32'(chg_flag), 1);
    chk("R5 int_n", 32'(int_n), 0);
    // R3 order and skip, R4 hold length
    e = 0;
    for (int i = 0; i < N; i++) begin
      if (m1[i]) begin
        chk("R3 order", 32'(log_sel[(base + e) % 4096]), 32'(i));
        chk("R4 hold", 32'(log_len[(base + e) % 4096]), 2);
        e++;
      end
    end
    chk("R3 run count", 32'(nlog - base), 32'(pop(m1)));
    chk("R4 status", 32'(sw_status), 32'(sw & m1));
    read_stat();
    chk("R7 flag clear", 32'(chg_flag), 0);
    chk("R7 int_n", 32'(int_n), 1);
    tick(70);
    chk("R6 no change", 32'(chg_flag), 0);
    sw[1] = ~sw[1];
    tick(70);
    chk("R6 disabled toggle", 32'(chg_flag), 0);
    chk("R6 disabled status", 32'(sw_status[1]), 0);
    chk("R9 period above pass", 32'(start_gap(0)), 60);
    cfg_write(2'd3, 16'd4);
    tick(60);
    lp = pop(m1) * 2;
    chk("R9 period below pass", 32'(start_gap(0)), 32'(lp));

    // sweep of single-input changes over the full mask
    cfg_write(2'd3, 16'd40);
    cfg_write(2'd2, 16'd1);
    en_mask = '1;
    tick(100);
    wait_gap();
    read_stat();
    for (int i = 0; i < N; i++) begin
      sw[i] = ~sw[i];
      tick(85);
      chk($sformatf("R6 change ch%0d", i), 32'(chg_flag), 1);
      chk($sformatf("R4 status ch%0d", i), 32'(sw_status), 32'(sw));
      wait_gap();
      read_stat();
    end
    chk("R7 cleared after sweep", 32'(chg_flag), 0);

    // R8 read in the pass-end cycle of a changing pass
    wait_gap();
    sw[5] = ~sw[5];
    k = 0;
    while (k < 200) begin
      tick(); k++;
      if (ch_valid && ch_sel == 5'd23 && cur_run == 1) break;
    end
    stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    chk("R8 read race", 32'(chg_flag), 1);
    wait_gap();
    read_stat();

    // R10 stop at the next boundary
    cfg_write(2'd2, 16'd3);
    k = 0;
    while (k < 300) begin
      tick(); k++;
      if (ch_valid && ch_sel == 5'd10 && cur_run == 1) break;
    end
    cfg_write(2'd0, 16'd0);
    tick(60);
    chk("R10 stopped", 32'(ch_valid), 0);
    chk("R10 last sel", 32'(log_sel[(nlog - 1) % 4096]), 10);
    chk("R10 last hold", 32'(log_len[(nlog - 1) % 4096]), 3);
    chk("R10 no pass end", 32'(chg_flag), 0);
    cfg_write(2'd0, 16'd1);
    tick(90);
    chk("R10 new first pass", 32'(chg_flag), 1);

    // R11 empty mask
    cfg_write(2'd0, 16'd0);
    tick(5);
    en_mask = '0;
    read_stat();
    base = nlog;
    cfg_write(2'd0, 16'd1);
    tick(20);
    chk("R11 first pass flag", 32'(chg_flag), 1);
    read_stat();
    sw = ~sw;
    tick(100);
    chk("R11 no change flag", 32'(chg_flag), 0);
    chk("R11 nothing selected", 32'(nlog - base), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule